// File: doc/BRIEF.md
# MAC learning table with aging

This block makes the forwarding decision for a small learning Ethernet switch. For each received frame it is handed the destination address, the source address, the ingress port number and a free-running timestamp. It first learns the source: an unknown source gets a new table entry holding its port and the timestamp, while a known source only has its timestamp refreshed. It then looks up the destination and returns a port mask. The mask has a single bit set for a known unicast destination. It has every bit except the ingress port set when the frame must be flooded.

The table is a fully associative store of 16 entries. Each entry holds an address, a port and a last-use timestamp. Entries age out lazily. Nothing scans the table in the background. An entry older than the time-to-live is discarded only when a destination lookup finds it. When the table is full, a new source takes the slot whose last use lies furthest in the past.

Control is one state machine with four named states:
- IDLE waits for `req_valid` and latches the request (transition IDLE→LEARN).
- LEARN writes or refreshes the source entry (LEARN→LOOKUP).
- LOOKUP searches the updated table, deletes an expired hit and registers the mask (LOOKUP→DONE).
- DONE presents the decision for one cycle (DONE→IDLE).

Top module: `mac_learn_fwd`

## Requirements
- R1: After reset `dec_valid` and `dec_mask` are 0 and the table holds no entries, so the first frame's destination is a miss.
- R2: A request accepted in IDLE yields `dec_valid` high for exactly one cycle, 3 clock edges after the edge that sampled `req_valid`. `dec_mask` is 0 whenever `dec_valid` is low.
- R3: A destination with no matching entry is flooded: the mask has every port bit set except bit `req_port`.
- R4: A group destination is flooded even when its address is in the table. The group bit is `req_dst[40]`, which is the least significant bit of the first address byte `req_dst[47:40]`.
- R5: The broadcast destination (all 48 bits one) is flooded.
- R6: A destination that matches a live entry gets a mask with only the bit of that entry's stored port set.
- R7: An unknown source is stored with `req_port` and `req_now` before the lookup runs, so a frame whose destination equals its own source gets the one-hot mask of its ingress port.
- R8: A known source only has its timestamp set to `req_now`. Its stored port is kept even when the frame arrives on another port, and even when the entry has already expired.
- R9: A destination entry whose age (`req_now` minus its timestamp, modulo 2^TS_W) is greater than AGE_LIMIT is removed and the frame is flooded. An age equal to AGE_LIMIT is still a hit. Once removed, the address is learned anew with its next ingress port.
- R10: A destination hit does not refresh the timestamp of the entry it hits.
- R11: A new source goes to the lowest free slot. When no slot is free, it replaces the entry with the largest age relative to `req_now`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Frame request strobe, honoured in IDLE |
| req_dst | input | 48 | Destination address (first byte in bits 47:40) |
| req_src | input | 48 | Source address |
| req_port | input | PORT_W | Ingress port number |
| req_now | input | TS_W | Current timestamp |
| dec_valid | output | 1 | Decision strobe, one cycle |
| dec_mask | output | NUM_PORTS | Egress port mask |

## Verification
Within one frame, source learning and destination lookup can land on the same table entry: the lookup runs one cycle after the write it depends on. The bench provokes this in three ways:
- sending a frame whose destination is its own new source;
- sending from an already-known source on a different port and then looking it up;
- refreshing an expired source entry before it is looked up.

Each case is judged by the egress mask, which reveals the stored port. The mask must point to the port of the first learning, never to the later ingress port and never to a flood.

// File: rtl/mlt_pkg.sv
package mlt_pkg;

    localparam int MAC_W     = 48;
    localparam int GROUP_BIT = 40;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LEARN  = 2'd1,
        ST_LOOKUP = 2'd2,
        ST_DONE   = 2'd3
    } fsm_t;

    function automatic logic is_group(input logic [MAC_W-1:0] addr);
        return addr[GROUP_BIT];
    endfunction

    function automatic logic is_bcast(input logic [MAC_W-1:0] addr);
        return &addr;
    endfunction

endpackage

// File: rtl/mlt_match.sv
module mlt_match #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]                     ent_valid,
    input  logic [ENTRIES-1:0][mlt_pkg::MAC_W-1:0] ent_addr,
    input  logic [mlt_pkg::MAC_W-1:0]              key,
    output logic [ENTRIES-1:0]                     hit_vec,
    output logic                                   hit,
    output logic [IDX_W-1:0]                       hit_idx
);

    // one comparator per slot
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = ent_valid[g] && (ent_addr[g] == key);
    end

    assign hit = |hit_vec;

    // encode the matching slot; lowest index wins if ever more than one
    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/mlt_victim.sv
module mlt_victim #(
    parameter int ENTRIES = 16,
    parameter int TS_W    = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]           ent_valid,
    input  logic [ENTRIES-1:0][TS_W-1:0] ent_stamp,
    input  logic [TS_W-1:0]              now,
    output logic [IDX_W-1:0]             victim_idx
);

    logic [ENTRIES-1:0][TS_W-1:0] age;
    logic                         found_free;
    logic [TS_W-1:0]              best_age;
    logic [IDX_W-1:0]             best_idx;

    // age relative to the current time survives counter wrap
    for (genvar g = 0; g < ENTRIES; g++) begin : g_age
        assign age[g] = now - ent_stamp[g];
    end

    always_comb begin
        found_free = 1'b0;
        best_age   = '0;
        best_idx   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found_free) begin
                if (!ent_valid[i]) begin
                    found_free = 1'b1;
                    best_idx   = IDX_W'(i);
                end else if (age[i] > best_age) begin
                    best_age = age[i];
                    best_idx = IDX_W'(i);
                end
            end
        end
    end

    assign victim_idx = best_idx;

endmodule

// File: rtl/mlt_table.sv
module mlt_table #(
    parameter int ENTRIES = 16,
    parameter int PORT_W  = 2,
    parameter int TS_W    = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    // create a slot
    input  logic                                   ins_en,
    input  logic [IDX_W-1:0]                       ins_idx,
    input  logic [mlt_pkg::MAC_W-1:0]              ins_addr,
    input  logic [PORT_W-1:0]                      ins_port,
    input  logic [TS_W-1:0]                        ins_stamp,
    // refresh a slot's timestamp
    input  logic                                   touch_en,
    input  logic [IDX_W-1:0]                       touch_idx,
    input  logic [TS_W-1:0]                        touch_stamp,
    // drop a slot
    input  logic                                   kill_en,
    input  logic [IDX_W-1:0]                       kill_idx,
    // contents
    output logic [ENTRIES-1:0]                     ent_valid,
    output logic [ENTRIES-1:0][mlt_pkg::MAC_W-1:0] ent_addr,
    output logic [ENTRIES-1:0][PORT_W-1:0]         ent_port,
    output logic [ENTRIES-1:0][TS_W-1:0]           ent_stamp
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic                      v_q;
        logic [mlt_pkg::MAC_W-1:0] a_q;
        logic [PORT_W-1:0]         p_q;
        logic [TS_W-1:0]           t_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                a_q <= '0;
                p_q <= '0;
                t_q <= '0;
            end else begin
                if (ins_en && (ins_idx == IDX_W'(g))) begin
                    v_q <= 1'b1;
                    a_q <= ins_addr;
                    p_q <= ins_port;
                    t_q <= ins_stamp;
                end else if (touch_en && (touch_idx == IDX_W'(g))) begin
                    t_q <= touch_stamp;
                end
                if (kill_en && (kill_idx == IDX_W'(g))) begin
                    v_q <= 1'b0;
                end
            end
        end

        assign ent_valid[g] = v_q;
        assign ent_addr[g]  = a_q;
        assign ent_port[g]  = p_q;
        assign ent_stamp[g] = t_q;
    end

endmodule

// File: rtl/mlt_mask.sv
module mlt_mask #(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 2
) (
    input  logic                 flood,
    input  logic [PORT_W-1:0]    ingress,
    input  logic [PORT_W-1:0]    egress,
    output logic [NUM_PORTS-1:0] mask
);

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_bit
        assign mask[g] = flood ? (ingress != PORT_W'(g))
                               : (egress  == PORT_W'(g));
    end

endmodule

// File: rtl/mac_learn_fwd.sv
module mac_learn_fwd #(
    parameter int NUM_PORTS = 4,
    parameter int ENTRIES   = 16,
    parameter int TS_W      = 16,
    parameter int AGE_LIMIT = 100,
    localparam int PORT_W   = $clog2(NUM_PORTS),
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [mlt_pkg::MAC_W-1:0] req_dst,
    input  logic [mlt_pkg::MAC_W-1:0] req_src,
    input  logic [PORT_W-1:0]         req_port,
    input  logic [TS_W-1:0]           req_now,
    output logic                      dec_valid,
    output logic [NUM_PORTS-1:0]      dec_mask
);

    import mlt_pkg::*;

    localparam logic [TS_W-1:0] LIMIT = TS_W'(AGE_LIMIT);

    fsm_t state_q, state_d;

    // latched request
    logic [MAC_W-1:0]  cap_dst, cap_src;
    logic [PORT_W-1:0] cap_port;
    logic [TS_W-1:0]   cap_now;

    // table contents
    logic [ENTRIES-1:0]             ent_valid;
    logic [ENTRIES-1:0][MAC_W-1:0]  ent_addr;
    logic [ENTRIES-1:0][PORT_W-1:0] ent_port;
    logic [ENTRIES-1:0][TS_W-1:0]   ent_stamp;

    // searches
    logic [ENTRIES-1:0] src_hit_vec, dst_hit_vec;
    logic               src_hit, dst_hit;
    logic [IDX_W-1:0]   src_idx, dst_idx, victim_idx;

    // write controls
    logic ins_en, touch_en, kill_en;

    // lookup result
    logic [TS_W-1:0]      dst_age;
    logic                 dst_expired, flood;
    logic [NUM_PORTS-1:0] mask_next, mask_q;

    mlt_table #(
        .ENTRIES(ENTRIES), .PORT_W(PORT_W), .TS_W(TS_W), .IDX_W(IDX_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins_en     (ins_en),
        .ins_idx    (victim_idx),
        .ins_addr   (cap_src),
        .ins_port   (cap_port),
        .ins_stamp  (cap_now),
        .touch_en   (touch_en),
        .touch_idx  (src_idx),
        .touch_stamp(cap_now),
        .kill_en    (kill_en),
        .kill_idx   (dst_idx),
        .ent_valid  (ent_valid),
        .ent_addr   (ent_addr),
        .ent_port   (ent_port),
        .ent_stamp  (ent_stamp)
    );

    mlt_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_src_match (
        .ent_valid(ent_valid),
        .ent_addr (ent_addr),
        .key      (cap_src),
        .hit_vec  (src_hit_vec),
        .hit      (src_hit),
        .hit_idx  (src_idx)
    );

    mlt_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_dst_match (
        .ent_valid(ent_valid),
        .ent_addr (ent_addr),
        .key      (cap_dst),
        .hit_vec  (dst_hit_vec),
        .hit      (dst_hit),
        .hit_idx  (dst_idx)
    );

    mlt_victim #(.ENTRIES(ENTRIES), .TS_W(TS_W), .IDX_W(IDX_W)) u_victim (
        .ent_valid (ent_valid),
        .ent_stamp (ent_stamp),
        .now       (cap_now),
        .victim_idx(victim_idx)
    );

    // learning acts in LEARN, before the lookup reads the table
    assign ins_en   = (state_q == ST_LEARN) && !src_hit;
    assign touch_en = (state_q == ST_LEARN) &&  src_hit;

    // lazy ageing: an expired hit is dropped while it is looked up
    assign dst_age     = cap_now - ent_stamp[dst_idx];
    assign dst_expired = dst_hit && (dst_age > LIMIT);
    assign kill_en     = (state_q == ST_LOOKUP) && dst_expired;
    assign flood       = !dst_hit || dst_expired
                         || is_group(cap_dst) || is_bcast(cap_dst);

    mlt_mask #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_mask (
        .flood  (flood),
        .ingress(cap_port),
        .egress (ent_port[dst_idx]),
        .mask   (mask_next)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_LEARN;
            ST_LEARN:  state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // request latch and decision register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_dst  <= '0;
            cap_src  <= '0;
            cap_port <= '0;
            cap_now  <= '0;
            mask_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        cap_dst  <= req_dst;
                        cap_src  <= req_src;
                        cap_port <= req_port;
                        cap_now  <= req_now;
                    end
                end
                ST_LOOKUP: mask_q <= mask_next;
                default:   ;
            endcase
        end
    end

    assign dec_valid = (state_q == ST_DONE);
    assign dec_mask  = dec_valid ? mask_q : '0;

endmodule

// File: rtl/mlt_checker.sv
module mlt_checker #(
    parameter int NUM_PORTS = 4,
    parameter int ENTRIES   = 16,
    parameter int PORT_W    = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic [mlt_pkg::MAC_W-1:0] req_dst,
    input logic [PORT_W-1:0]         req_port,
    input logic                      dec_valid,
    input logic [NUM_PORTS-1:0]      dec_mask,
    input logic [ENTRIES-1:0]        src_hit_vec,
    input logic [ENTRIES-1:0]        dst_hit_vec
);

    localparam logic [NUM_PORTS-1:0] ONE = NUM_PORTS'(1);

    // R2
    latency_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(req_valid, 3));

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R6
    mask_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_mask != '0));

    // R3
    flood_skips_ingress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && ($countones(dec_mask) > 1)) |-> !dec_mask[$past(req_port, 3)]);

    // R5
    bcast_flood_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (&($past(req_dst, 3)))) |-> (dec_mask == ~(ONE << $past(req_port, 3))));

    // R8
    src_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_hit_vec));

    // R7
    dst_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dst_hit_vec));

endmodule

bind mac_learn_fwd mlt_checker #(
    .NUM_PORTS(NUM_PORTS), .ENTRIES(ENTRIES), .PORT_W(PORT_W)
) u_mlt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_dst    (req_dst),
    .req_port   (req_port),
    .dec_valid  (dec_valid),
    .dec_mask   (dec_mask),
    .src_hit_vec(src_hit_vec),
    .dst_hit_vec(dst_hit_vec)
);

// File: tb/test_mac_learn_fwd.sv
`timescale 1ns/1ps
module test_mac_learn_fwd;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [47:0] req_dst = '0;
    logic [47:0] req_src = '0;
    logic [1:0]  req_port = '0;
    logic [15:0] req_now = '0;
    logic        dec_valid;
    logic [3:0]  dec_mask;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [3:0] mask;
        int         issue;
        string      tag;
    } exp_t;

    exp_t sb[$];

    mac_learn_fwd #(.NUM_PORTS(4), .ENTRIES(16), .TS_W(16), .AGE_LIMIT(100)) i_mac_learn_fwd (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dst(req_dst),
        .req_src(req_src), .req_port(req_port), .req_now(req_now),
        .dec_valid(dec_valid), .dec_mask(dec_mask)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [47:0] mac(input int n);
        return {8'h02, 32'h0, 8'(n)};
    endfunction

    localparam logic [47:0] BCAST = '1;
    localparam logic [47:0] GRP_A = 48'h01005E000001;
    localparam logic [47:0] GRP_B = 48'h01005E000002;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", checks, fails);
    endtask

    // driver: one request, expected result into the scoreboard
    task automatic send(input logic [47:0] d, input logic [47:0] s, input int p,
                        input int t, input logic [3:0] m, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_dst   = d;
        req_src   = s;
        req_port  = 2'(p);
        req_now   = 16'(t);
        e.mask  = m;
        e.issue = cyc;
        e.tag   = tag;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // monitor: pops and compares each decision
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (dec_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2 unexpected decision", int'(dec_mask), 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(dec_mask == e.mask, e.tag, int'(dec_mask), int'(e.mask));
                    check((cyc - e.issue) == 3, "R2 latency", cyc - e.issue, 3);
                end
            end else if (dec_mask != 4'h0) begin
                check(1'b0, "R2 mask while idle", int'(dec_mask), 0);
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dec_valid == 1'b0, "R1 dec_valid after reset", int'(dec_valid), 0);
        check(dec_mask == 4'h0, "R1 dec_mask after reset", int'(dec_mask), 0);

        // R1 empty table, R3 miss floods
        send(mac(1), mac(0), 0, 10, 4'b1110, "R3 miss on empty table R1");
        send(mac(0), mac(1), 1, 20, 4'b0001, "R6 unicast hit");
        send(mac(1), mac(1), 3, 30, 4'b0010, "R8 known source keeps port");
        send(mac(2), mac(2), 2, 40, 4'b0100, "R7 learn before lookup");
        send(BCAST,  mac(0), 0, 50, 4'b1110, "R5 broadcast");
        send(GRP_A,  mac(3), 3, 55, 4'b0111, "R4 group unknown");
        send(mac(0), GRP_B,  2, 60, 4'b0001, "R6 hit after group source");
        send(GRP_B,  mac(3), 3, 61, 4'b0111, "R4 group learned still floods");
        // mac(0) last used at 50
        send(mac(0), mac(3), 3, 150, 4'b0001, "R9 age equal to limit hits");
        send(mac(0), mac(3), 3, 151, 4'b0111, "R10 hit did not refresh");
        send(mac(0), mac(2), 2, 152, 4'b1011, "R9 expired entry removed");
        send(mac(3), mac(0), 1, 153, 4'b1000, "R9 relearn setup");
        send(mac(0), mac(3), 3, 154, 4'b0010, "R9 relearned on new port");
        // mac(1) expired (last 30) but refreshed as source
        send(mac(2), mac(1), 3, 200, 4'b0100, "R8 expired source refreshed");
        send(mac(1), mac(2), 2, 201, 4'b0010, "R8 refreshed keeps port");
        send(BCAST,  GRP_B,  2, 205, 4'b1011, "R11 refresh group entry");
        for (int k = 0; k < 11; k++) begin
            send(BCAST, mac(16 + k), 0, 210 + k, 4'b1110, "R11 fill table");
        end
        // full: oldest is mac(0) at 153, next mac(3) at 154
        send(BCAST,   mac(30), 2, 230, 4'b1011, "R11 evicting insert");
        send(mac(0),  mac(30), 2, 231, 4'b1011, "R11 oldest evicted");
        send(mac(3),  mac(30), 2, 232, 4'b1000, "R11 second oldest kept");
        send(mac(30), mac(31), 1, 233, 4'b0100, "R11 new entry hit");
        send(mac(3),  mac(31), 1, 234, 4'b1101, "R11 next oldest evicted");

        repeat (5) @(negedge clk);
        check(sb.size() == 0, "R2 all decisions seen", sb.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule